// File: doc/BRIEF.md
# Exception Entry and Return Controller

This block sits beside the fetch stage of a 32-bit processor and decides, one cycle at a time, whether the core enters an exception and where it goes. It takes a bit mask of pending causes, each bit standing for one cause index. It picks one cause, classes it as an ordinary trap or a debug trap, and forms the vector address from a base register plus a fixed per-cause stride. It then issues, in the next cycle, a PC redirect, a write strobe for the matching return-address register with the faulting PC, and a new value for the interrupt-enable status bits.

The same block carries out the two return instructions as a plain restore. A return from an ordinary trap jumps to the saved exception address and takes the enable bit back from its exception copy. A debug return does the same from the breakpoint address and breakpoint copy. A control input can steer ordinary traps to the debug base, which is how a debugger takes over the whole vector table. Debug traps use the debug base in every case.

All pins are plain control and status signals sampled on every rising clock edge. Nothing streams through the block, so there is no valid/ready handshake. The caller must hold a request until it sees the redirect for it, and the pipeline flush that follows is the caller's job.

Top module: `exc_entry_ctrl`

## Requirements
- R1: On entry, the redirect address is the selected base with its bits [7:0] replaced by cause index times 32. The cause indices are: 0 reset, 1 breakpoint, 2 instruction bus error, 3 watchpoint, 4 data bus error, 5 divide by zero, 6 external interrupt, 7 system call. The taken index appears on `cause_o`.
- R2: When several eligible request bits are set, the lowest index is taken.
- R3: Causes 0, 2, 4, 5, 6 and 7 are ordinary and pulse `ea_we_o`. Causes 1 and 3 are debug and pulse `ba_we_o`. Either way `save_pc_o` carries the sampled `pc_i`, and the two strobes are never high together.
- R4: The enable field is `ie[0]` global enable, `ie[1]` exception copy, `ie[2]` breakpoint copy. On ordinary entry, `ie_o` = {ie[2], ie[0], 0} with `ie_we_o` high.
- R5: On debug entry, `ie_o` = {ie[0], ie[1], 0} with `ie_we_o` high.
- R6: Ordinary entries vector from `eba_i`, or from `deba_i` when `remap_i` is high.
- R7: Debug entries vector from `deba_i` whatever `remap_i` is.
- R8: Request bit 6 is ignored while `ie_i[0]` is low. The remaining request bits are still served.
- R9: With no eligible request, `eret_i` redirects to `ea_i` with `ie_o` = {ie[2], ie[1], ie[1]}. Otherwise `bret_i` redirects to `ba_i` with `ie_o` = {ie[2], ie[1], ie[2]}. `eret_i` wins over `bret_i`, and neither raises `ea_we_o` or `ba_we_o`.
- R10: Outputs are registered. Every result appears one clock after its inputs are sampled. In reset, and in any cycle with no eligible request and no return, every strobe and the redirect are low.
- R11: Bits [7:0] of `eba_i` and `deba_i` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 8 | Pending cause mask, bit n = cause index n |
| pc_i | input | 32 | PC of the instruction being trapped |
| ie_i | input | 3 | Current enable field {bp copy, exc copy, global} |
| eba_i | input | 32 | Ordinary vector base |
| deba_i | input | 32 | Debug vector base |
| remap_i | input | 1 | Steer ordinary traps to the debug base |
| eret_i | input | 1 | Return from ordinary trap |
| bret_i | input | 1 | Return from debug trap |
| ea_i | input | 32 | Current exception return address |
| ba_i | input | 32 | Current breakpoint return address |
| redirect_o | output | 1 | PC redirect strobe |
| redirect_pc_o | output | 32 | New PC |
| ea_we_o | output | 1 | Write `save_pc_o` to the exception return register |
| ba_we_o | output | 1 | Write `save_pc_o` to the breakpoint return register |
| save_pc_o | output | 32 | Faulting PC to save |
| ie_we_o | output | 1 | Write `ie_o` to the enable field |
| ie_o | output | 3 | New enable field |
| cause_o | output | 3 | Taken cause index |

## Verification
The bench builds the block with its default parameters: eight causes, a 32-byte stride, and the interrupt at index 6. With those values every combination of request mask, enable field, remap flag and return inputs comes to 16384 cases, and the bench sweeps all of them. That sweep covers every priority tie, every masked-interrupt case and every conflict between an entry and a return. The base inputs carry nonzero low bytes throughout, and the PC changes from case to case, so a leaked base bit or a stale saved PC shows up in the expected values.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int NCAUSE    = 8;
  localparam int VEC_SHIFT = 5;
  localparam int IRQ_IDX   = 6;
  // causes that belong to the debug class (breakpoint, watchpoint)
  localparam logic [NCAUSE-1:0] DBG_MASK = 8'b0000_1010;
  // enable field bit positions
  localparam int IE_GLB = 0;
  localparam int IE_EXC = 1;
  localparam int IE_BRK = 2;
  localparam int IE_W   = 3;
endpackage

// File: rtl/exc_prio_pick.sv
module exc_prio_pick #(
  parameter int N = 8,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  // scan from the top so the lowest set bit is written last
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (req_i[k]) begin
        any_o = 1'b1;
        idx_o = IW'(k);
      end
    end
  end
endmodule

// File: rtl/exc_vec_gen.sv
module exc_vec_gen #(
  parameter int XLEN  = 32,
  parameter int CW    = 3,
  parameter int SHIFT = 5,
  localparam int LOW  = CW + SHIFT
) (
  input  logic [XLEN-1:0] base_i,
  input  logic [CW-1:0]   cause_i,
  output logic [XLEN-1:0] vec_o
);
  // the low byte of the base is treated as zero, so no carry reaches it
  assign vec_o = {base_i[XLEN-1:LOW], cause_i, {SHIFT{1'b0}}};
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_pkg::*;
#(
  parameter int XLEN = 32,
  localparam int CW  = $clog2(NCAUSE),
  localparam int LOW = CW + VEC_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCAUSE-1:0] req_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [IE_W-1:0]   ie_i,
  input  logic [XLEN-1:0]   eba_i,
  input  logic [XLEN-1:0]   deba_i,
  input  logic              remap_i,
  input  logic              eret_i,
  input  logic              bret_i,
  input  logic [XLEN-1:0]   ea_i,
  input  logic [XLEN-1:0]   ba_i,
  output logic              redirect_o,
  output logic [XLEN-1:0]   redirect_pc_o,
  output logic              ea_we_o,
  output logic              ba_we_o,
  output logic [XLEN-1:0]   save_pc_o,
  output logic              ie_we_o,
  output logic [IE_W-1:0]   ie_o,
  output logic [CW-1:0]     cause_o
);
  logic [NCAUSE-1:0] elig;
  logic              take;
  logic [CW-1:0]     cidx;
  logic              is_dbg;
  logic [XLEN-1:0]   base_sel, vec;

  // interrupt gate: bit IRQ_IDX counts only with global enable set
  always_comb begin
    elig = req_i;
    if (!ie_i[IE_GLB]) elig[IRQ_IDX] = 1'b0;
  end

  exc_prio_pick #(.N(NCAUSE)) u_pick (
    .req_i (elig),
    .any_o (take),
    .idx_o (cidx)
  );

  assign is_dbg   = DBG_MASK[cidx];
  assign base_sel = (is_dbg || remap_i) ? deba_i : eba_i;

  exc_vec_gen #(.XLEN(XLEN), .CW(CW), .SHIFT(VEC_SHIFT)) u_vec (
    .base_i  (base_sel),
    .cause_i (cidx),
    .vec_o   (vec)
  );

  logic              n_redir, n_ea_we, n_ba_we, n_ie_we;
  logic [XLEN-1:0]   n_pc;
  logic [IE_W-1:0]   n_ie;

  always_comb begin
    n_redir = 1'b0;
    n_ea_we = 1'b0;
    n_ba_we = 1'b0;
    n_ie_we = 1'b0;
    n_pc    = vec;
    n_ie    = ie_i;
    if (take) begin
      n_redir        = 1'b1;
      n_ie_we        = 1'b1;
      n_ie[IE_GLB]   = 1'b0;
      if (is_dbg) begin
        n_ba_we      = 1'b1;
        n_ie[IE_BRK] = ie_i[IE_GLB];
      end else begin
        n_ea_we      = 1'b1;
        n_ie[IE_EXC] = ie_i[IE_GLB];
      end
    end else if (eret_i) begin
      n_redir      = 1'b1;
      n_ie_we      = 1'b1;
      n_pc         = ea_i;
      n_ie[IE_GLB] = ie_i[IE_EXC];
    end else if (bret_i) begin
      n_redir      = 1'b1;
      n_ie_we      = 1'b1;
      n_pc         = ba_i;
      n_ie[IE_GLB] = ie_i[IE_BRK];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      redirect_o    <= 1'b0;
      ea_we_o       <= 1'b0;
      ba_we_o       <= 1'b0;
      ie_we_o       <= 1'b0;
      redirect_pc_o <= '0;
      save_pc_o     <= '0;
      ie_o          <= '0;
      cause_o       <= '0;
    end else begin
      redirect_o    <= n_redir;
      ea_we_o       <= n_ea_we;
      ba_we_o       <= n_ba_we;
      ie_we_o       <= n_ie_we;
      redirect_pc_o <= n_pc;
      save_pc_o     <= pc_i;
      ie_o          <= n_ie;
      cause_o       <= cidx;
    end
  end

  p_one_class_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ea_we_o, ba_we_o}));

  p_save_pc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ea_we_o || ba_we_o) |-> save_pc_o == $past(pc_i));

  p_glb_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ea_we_o || ba_we_o) |-> (ie_we_o && redirect_o && !ie_o[IE_GLB]));

  p_dbg_base_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ba_we_o |-> redirect_pc_o[XLEN-1:LOW] == $past(deba_i[XLEN-1:LOW]));

  p_irq_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i == (NCAUSE'(1) << IRQ_IDX) && !ie_i[IE_GLB] && !eret_i && !bret_i)
      |=> !redirect_o);

  p_eret_target_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (eret_i && !take) |=> (redirect_o && !ea_we_o && !ba_we_o
                           && redirect_pc_o == $past(ea_i)));
endmodule

// File: tb/exc_entry_ctrl_tb_top.sv
module exc_entry_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  req_i;
  logic [31:0] pc_i, eba_i, deba_i, ea_i, ba_i;
  logic [2:0]  ie_i;
  logic        remap_i, eret_i, bret_i;
  logic        redirect_o, ea_we_o, ba_we_o, ie_we_o;
  logic [31:0] redirect_pc_o, save_pc_o;
  logic [2:0]  ie_o, cause_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  exc_entry_ctrl dut_i (
    .clk, .rst_n, .req_i, .pc_i, .ie_i, .eba_i, .deba_i, .remap_i,
    .eret_i, .bret_i, .ea_i, .ba_i, .redirect_o, .redirect_pc_o,
    .ea_we_o, .ba_we_o, .save_pc_o, .ie_we_o, .ie_o, .cause_o
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL R10 watchdog act=%h exp=%h", 32'd0, 32'd1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_i = '0; pc_i = '0; ie_i = '0;
    eba_i = 32'h1234_56A5; deba_i = 32'hABCD_EF3C;   // low bytes nonzero: R11
    ea_i = 32'h0000_4440; ba_i = 32'h0000_8880;
    remap_i = 1'b0; eret_i = 1'b0; bret_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(!redirect_o && !ea_we_o && !ba_we_o && !ie_we_o, "R10 reset",
        {28'd0, redirect_o, ea_we_o, ba_we_o, ie_we_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!redirect_o && !ie_we_o, "R10 idle", {30'd0, redirect_o, ie_we_o}, 32'd0);

    for (int v = 0; v < 16384; v++) begin
      logic [7:0]  rq, el;
      logic [2:0]  ie, eie;
      logic        rm, er, br, tk, dbg;
      logic [31:0] pc, base, epc;
      int          c;
      rq = v[7:0]; ie = v[10:8]; rm = v[11]; er = v[12]; br = v[13];
      pc = 32'h2000_0000 + (v * 4);
      req_i = rq; ie_i = ie; remap_i = rm; eret_i = er; bret_i = br; pc_i = pc;
      // vary the discarded low byte of the bases every case (R11)
      eba_i[7:0] = v[7:0] ^ 8'h5A; deba_i[7:0] = v[8:1] ^ 8'hC3;
      // expected values
      el = rq;
      if (!ie[0]) el[6] = 1'b0;                    // R8
      tk = (el != 0);
      c = 0;
      for (int k = 7; k >= 0; k--) if (el[k]) c = k;  // R2
      dbg = (c == 1 || c == 3);
      base = (dbg || rm) ? 32'hABCD_EF00 : 32'h1234_5600;
      epc = base + 32'(c * 32);
      @(negedge clk);
      if (tk) begin
        chk(redirect_o && redirect_pc_o == epc, dbg ? "R7 R1 vector" :
            (rm ? "R6 R1 remap vector" : "R1 R11 vector"), redirect_pc_o, epc);
        chk(cause_o == 3'(c), "R2 cause", {29'd0, cause_o}, 32'(c));
        chk(ea_we_o == !dbg && ba_we_o == dbg && save_pc_o == pc, "R3 save",
            {ea_we_o, ba_we_o, save_pc_o[29:0]}, {!dbg, dbg, pc[29:0]});
        eie = dbg ? {ie[0], ie[1], 1'b0} : {ie[2], ie[0], 1'b0};
        chk(ie_we_o && ie_o == eie, dbg ? "R5 ie" : "R4 ie",
            {29'd0, ie_o}, {29'd0, eie});
      end else if (er || br) begin
        eie = er ? {ie[2], ie[1], ie[1]} : {ie[2], ie[1], ie[2]};
        chk(redirect_o && redirect_pc_o == (er ? ea_i : ba_i) && !ea_we_o && !ba_we_o,
            "R9 ret target", redirect_pc_o, er ? ea_i : ba_i);
        chk(ie_we_o && ie_o == eie, "R9 ret ie", {29'd0, ie_o}, {29'd0, eie});
      end else begin
        chk(!redirect_o && !ea_we_o && !ba_we_o && !ie_we_o, "R10 R8 quiet",
            {28'd0, redirect_o, ea_we_o, ba_we_o, ie_we_o}, 32'd0);
      end
    end
    req_i = '0; eret_i = 1'b0; bret_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(!redirect_o && !ie_we_o, "R10 idle end", {30'd0, redirect_o, ie_we_o}, 32'd0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule